// File: doc/BRIEF.md
# Voltage Regulator Command Sequencer

This block plays back a list of regulator command bytes held in a bank of 32 programmable entries. It hands each byte to a downstream serial engine, such as an I2C master, over a valid/ready handshake. A run begins at the entry chosen by the read pointer in the control register. A run starts on a software request, or on a frequency-change event when the coupling bit is set. Entries are taken in ascending order and the list is circular, so entry 0 follows entry 31.

Each entry carries a data byte and three flags. The delay flag holds the entry back for a programmed number of reference-clock ticks. The burst flag lets the next entry go out without waiting for the command-complete acknowledge. The final flag ends the run and leaves the pointer on that entry. The delay count is taken in single-cycle tick pulses that come from the 13 MHz reference, so the whole block stays in one clock domain.

Top module: `vreg_cmd_seq`

## Requirements
- R1: After reset, busy, done and byte_valid are 0 and rd_ptr is 0.
- R2: A sw_start pulse while idle starts a run at the entry rd_ptr names. The data bytes of the entries come out on byte_data in ascending entry order.
- R3: An entry at index 31 whose final flag is clear is followed by entry 0.
- R4: The handshake of an entry whose final flag is set ends the run. done is 1 for exactly the one cycle after that handshake, busy then falls to 0, and rd_ptr stays on that entry.
- R5: After the handshake of an entry whose burst and final flags are both clear, byte_valid stays 0 until a cmd_ack pulse is seen.
- R6: After the handshake of an entry whose burst flag is set, the next entry is sent with no cmd_ack.
- R7: An entry whose delay flag is set waits for a number of ref_tick pulses equal to the control delay field before byte_valid rises. The entry is sent at once when that field is 0 or when the flag is clear.
- R8: freq_chg starts a run only when the coupling bit of the control register is 1. When that bit is 0, freq_chg has no effect.
- R9: While byte_valid is 1 and byte_ready is 0, byte_valid stays 1 and byte_data does not change.
- R10: While busy is 1, sw_start, freq_chg and control register writes are ignored. The run continues unchanged and rd_ptr ends where the run alone puts it.
- R11: The bank write port stores bank_wdata at bank_addr with this encoding: bit 10 is the delay flag, bit 9 is the burst flag, bit 8 is the final flag, and bits 7:0 are the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_wr | input | 1 | Write strobe for the command bank |
| bank_addr | input | 5 | Entry index to write |
| bank_wdata | input | 11 | Entry value: {delay, burst, final, data[7:0]} |
| ctl_wr | input | 1 | Control register write strobe, taken only while idle |
| ctl_ptr | input | 5 | New read pointer value |
| ctl_dly | input | 8 | New delay count, in reference ticks |
| ctl_couple | input | 1 | New value of the frequency/voltage coupling bit |
| sw_start | input | 1 | Software start request |
| freq_chg | input | 1 | Frequency-change event |
| ref_tick | input | 1 | Single-cycle tick taken from the reference clock |
| cmd_ack | input | 1 | Command-complete acknowledge from the serial engine |
| byte_valid | output | 1 | A command byte is offered |
| byte_data | output | 8 | The offered command byte |
| byte_ready | input | 1 | The downstream engine accepts the byte |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| rd_ptr | output | 5 | Current read pointer |

## Verification
The main check is a sweep over every one of the 32 start positions. Each position gets a run length of one to six entries and its own pattern of burst flags, so some runs cross the 31-to-0 boundary and some do not. The mix of burst entries and acknowledged entries shows whether the sequencer waits for cmd_ack only where it should. Checking the final pointer shows whether the pointer stops on the final entry or one past it. Separate runs cover the delay path with a nonzero count, with a zero count and with the flag clear, a held-off byte_ready, freq_chg with the coupling bit clear and set, and start requests and control writes made during a run.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_DELAY = 3'd2,
    ST_SEND  = 3'd3,
    ST_WAITA = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic dly;
    logic burst;
    logic final_cmd;
  } cmd_flags_t;

  localparam int FLAG_W = 3;

endpackage

// File: rtl/vrseq_bank.sv
module vrseq_bank #(
  parameter int ENTRIES = 32,
  parameter int ENT_W   = 11,
  parameter int AW      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [ENT_W-1:0] rd_data
);

  logic [ENT_W-1:0] slot_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_en;
    assign slot_en = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_addr];

endmodule

// File: rtl/vrseq_ctl.sv
module vrseq_ctl #(
  parameter int ENTRIES = 32,
  parameter int AW      = 5,
  parameter int DLY_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [DLY_W-1:0] wr_dly,
  input  logic             wr_couple,
  input  logic             advance,
  output logic [AW-1:0]    ptr,
  output logic [DLY_W-1:0] dly,
  output logic             couple
);

  logic [AW-1:0]    ptr_q, ptr_d;
  logic [DLY_W-1:0] dly_q;
  logic             couple_q;
  logic             ptr_en;

  always_comb begin
    ptr_en = wr_en || advance;
    ptr_d  = ptr_q;
    if (wr_en) begin
      ptr_d = wr_ptr;
    end else if (advance) begin
      ptr_d = (ptr_q == AW'(ENTRIES - 1)) ? '0 : ptr_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q    <= '0;
      couple_q <= 1'b0;
    end else if (wr_en) begin
      dly_q    <= wr_dly;
      couple_q <= wr_couple;
    end
  end

  assign ptr    = ptr_q;
  assign dly    = dly_q;
  assign couple = couple_q;

endmodule

// File: rtl/vrseq_timer.sv
module vrseq_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic             expire
);

  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (run && tick);
    cnt_d  = load ? load_val : cnt_q - DLY_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = run && tick && (cnt_q == DLY_W'(1));

endmodule

// File: rtl/vrseq_fsm.sv
module vrseq_fsm
  import vrseq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  cmd_flags_t        ent_flags,
  input  logic [DATA_W-1:0] ent_data,
  input  logic [DLY_W-1:0]  dly_cfg,
  input  logic              expire,
  input  logic              byte_ready,
  input  logic              cmd_ack,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic              advance,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  output logic              busy,
  output logic              done
);

  seq_state_t        state_q, state_d;
  cmd_flags_t        cur_flags_q;
  logic [DATA_W-1:0] cur_data_q;
  logic              cur_ld;
  logic              done_q, done_d;

  always_comb begin
    state_d  = state_q;
    cur_ld   = 1'b0;
    tmr_load = 1'b0;
    advance  = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        cur_ld = 1'b1;
        if (ent_flags.dly && (dly_cfg != '0)) begin
          tmr_load = 1'b1;
          state_d  = ST_DELAY;
        end else begin
          state_d  = ST_SEND;
        end
      end
      ST_DELAY: begin
        if (expire) state_d = ST_SEND;
      end
      ST_SEND: begin
        if (byte_ready) begin
          if (cur_flags_q.final_cmd) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            advance = 1'b1;
            state_d = cur_flags_q.burst ? ST_CHECK : ST_WAITA;
          end
        end
      end
      ST_WAITA: begin
        if (cmd_ack) state_d = ST_CHECK;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_flags_q <= '0;
      cur_data_q  <= '0;
    end else if (cur_ld) begin
      cur_flags_q <= ent_flags;
      cur_data_q  <= ent_data;
    end
  end

  assign tmr_run    = (state_q == ST_DELAY);
  assign byte_valid = (state_q == ST_SEND);
  assign byte_data  = cur_data_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;

endmodule

// File: rtl/vreg_cmd_seq.sv
module vreg_cmd_seq
  import vrseq_pkg::*;
#(
  parameter  int ENTRIES = 32,
  parameter  int DATA_W  = 8,
  parameter  int DLY_W   = 8,
  localparam int AW      = $clog2(ENTRIES),
  localparam int ENT_W   = DATA_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic [AW-1:0]     bank_addr,
  input  logic [ENT_W-1:0]  bank_wdata,
  input  logic              ctl_wr,
  input  logic [AW-1:0]     ctl_ptr,
  input  logic [DLY_W-1:0]  ctl_dly,
  input  logic              ctl_couple,
  input  logic              sw_start,
  input  logic              freq_chg,
  input  logic              ref_tick,
  input  logic              cmd_ack,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  input  logic              byte_ready,
  output logic              busy,
  output logic              done,
  output logic [AW-1:0]     rd_ptr
);

  logic [ENT_W-1:0] ent_w;
  logic [DLY_W-1:0] dly_w;
  logic             couple_w;
  logic             advance_w;
  logic             tmr_load_w, tmr_run_w, expire_w;
  logic             start_req_w;
  logic             ctl_wr_idle_w;
  cmd_flags_t       ent_flags_w;

  assign ctl_wr_idle_w = ctl_wr && !busy;
  assign start_req_w   = sw_start || (freq_chg && couple_w);
  assign ent_flags_w   = ent_w[ENT_W-1 -: FLAG_W];

  vrseq_bank #(.ENTRIES(ENTRIES), .ENT_W(ENT_W), .AW(AW)) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_wr),
    .wr_addr (bank_addr),
    .wr_data (bank_wdata),
    .rd_addr (rd_ptr),
    .rd_data (ent_w)
  );

  vrseq_ctl #(.ENTRIES(ENTRIES), .AW(AW), .DLY_W(DLY_W)) ctl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (ctl_wr_idle_w),
    .wr_ptr    (ctl_ptr),
    .wr_dly    (ctl_dly),
    .wr_couple (ctl_couple),
    .advance   (advance_w),
    .ptr       (rd_ptr),
    .dly       (dly_w),
    .couple    (couple_w)
  );

  vrseq_timer #(.DLY_W(DLY_W)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load_w),
    .load_val (dly_w),
    .run      (tmr_run_w),
    .tick     (ref_tick),
    .expire   (expire_w)
  );

  vrseq_fsm #(.DATA_W(DATA_W), .DLY_W(DLY_W)) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_req_w),
    .ent_flags  (ent_flags_w),
    .ent_data   (ent_w[DATA_W-1:0]),
    .dly_cfg    (dly_w),
    .expire     (expire_w),
    .byte_ready (byte_ready),
    .cmd_ack    (cmd_ack),
    .tmr_load   (tmr_load_w),
    .tmr_run    (tmr_run_w),
    .advance    (advance_w),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .busy       (busy),
    .done       (done)
  );

endmodule

// File: rtl/vrseq_chk.sv
module vrseq_chk #(
  parameter int DATA_W = 8,
  parameter int AW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_valid,
  input logic              byte_ready,
  input logic [DATA_W-1:0] byte_data,
  input logic              busy,
  input logic              done,
  input logic [AW-1:0]     rd_ptr,
  input logic              ctl_wr,
  input logic              sw_start,
  input logic              couple_w
);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid && !byte_ready |=> byte_valid && $stable(byte_data));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  ctl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctl_wr && !(byte_valid && byte_ready) |=> $stable(rd_ptr));

  // R8
  uncoupled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !sw_start && !couple_w |=> !busy);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !byte_valid);

endmodule

bind vreg_cmd_seq vrseq_chk #(.DATA_W(DATA_W), .AW(AW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .byte_valid (byte_valid),
  .byte_ready (byte_ready),
  .byte_data  (byte_data),
  .busy       (busy),
  .done       (done),
  .rd_ptr     (rd_ptr),
  .ctl_wr     (ctl_wr),
  .sw_start   (sw_start),
  .couple_w   (couple_w)
);

// File: tb/vreg_cmd_seq_tb_top.sv
module vreg_cmd_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N_ENT      = 32;

  logic        clk, rst_n;
  logic        bank_wr;
  logic [4:0]  bank_addr;
  logic [10:0] bank_wdata;
  logic        ctl_wr;
  logic [4:0]  ctl_ptr;
  logic [7:0]  ctl_dly;
  logic        ctl_couple;
  logic        sw_start, freq_chg, ref_tick, cmd_ack;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready;
  logic        busy, done;
  logic [4:0]  rd_ptr;

  int errors = 0;
  int checks = 0;
  int cyc_n  = 0;
  int tick_cnt = 0;
  bit tick_en = 0;

  vreg_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .ctl_wr(ctl_wr), .ctl_ptr(ctl_ptr),
    .ctl_dly(ctl_dly), .ctl_couple(ctl_couple), .sw_start(sw_start),
    .freq_chg(freq_chg), .ref_tick(ref_tick), .cmd_ack(cmd_ack),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .busy(busy), .done(done), .rd_ptr(rd_ptr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(negedge clk);
    cyc_n++;
    ref_tick = tick_en && (cyc_n % 3 == 0);
    if (ref_tick) tick_cnt++;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prog(input int addr, input bit d, input bit b, input bit f, input int data);
    bank_wr = 1'b1; bank_addr = 5'(addr); bank_wdata = {d, b, f, 8'(data)};
    step();
    bank_wr = 1'b0;
  endtask

  task automatic setctl(input int p, input int d, input bit c);
    ctl_wr = 1'b1; ctl_ptr = 5'(p); ctl_dly = 8'(d); ctl_couple = c;
    step();
    ctl_wr = 1'b0;
  endtask

  task automatic pulse_start();
    sw_start = 1'b1; step(); sw_start = 1'b0;
  endtask

  // waits for a byte, holds ready low for hold cycles, then accepts it
  task automatic recv(input int exp, input string req, input int hold);
    int t = 0;
    while (!byte_valid && t < 2000) begin step(); t++; end
    chk(byte_valid, req, byte_valid, 1);
    chk(byte_data == 8'(exp), req, byte_data, exp);
    for (int h = 0; h < hold; h++) begin
      step();
      chk(byte_valid && byte_data == 8'(exp), "R9", byte_data, exp);
    end
    byte_ready = 1'b1;
    step();
    byte_ready = 1'b0;
  endtask

  function automatic int dval(input int s, input int i);
    return (s * 7 + i * 29 + 3) & 8'hFF;
  endfunction

  task automatic run_seq(input int s, input int n, input int mpat, input bit busy_poke);
    int a;
    for (int i = 0; i < n; i++) begin
      a = (s + i) % N_ENT;
      prog(a, 1'b0, mpat[i] && (i != n - 1), i == n - 1, dval(s, i));
    end
    setctl(s, 0, 1'b0);
    pulse_start();
    for (int i = 0; i < n; i++) begin
      a = (s + i) % N_ENT;
      recv(dval(s, i), (a == 0 && i > 0) ? "R3" : (mpat[i] ? "R6" : "R2"), (i == 0) ? 2 : 0);
      if (i == n - 1) begin
        chk(done == 1'b1, "R4", done, 1);
        step();
        chk(done == 1'b0 && busy == 1'b0, "R4", {done, busy}, 0);
        chk(rd_ptr == 5'(a), "R4", rd_ptr, a);
      end else if (!mpat[i]) begin
        if (busy_poke) begin
          sw_start = 1'b1; ctl_wr = 1'b1; ctl_ptr = 5'(s + 13); ctl_couple = 1'b1;
          freq_chg = 1'b1;
        end
        for (int w = 0; w < 3; w++) begin
          step();
          sw_start = 1'b0; ctl_wr = 1'b0; freq_chg = 1'b0;
          chk(byte_valid == 1'b0, "R5", byte_valid, 0);
        end
        cmd_ack = 1'b1; step(); cmd_ack = 1'b0;
      end
    end
    if (busy_poke) begin
      for (int w = 0; w < 4; w++) step();
      chk(busy == 1'b0, "R10", busy, 0);
      setctl(rd_ptr, 0, 1'b0);
    end
  endtask

  initial begin
    rst_n = 1'b0; bank_wr = 0; bank_addr = 0; bank_wdata = 0; ctl_wr = 0;
    ctl_ptr = 0; ctl_dly = 0; ctl_couple = 0; sw_start = 0; freq_chg = 0;
    ref_tick = 0; cmd_ack = 0; byte_ready = 0;
    repeat (3) step();
    chk(busy == 0 && done == 0 && byte_valid == 0, "R1", {busy, done, byte_valid}, 0);
    chk(rd_ptr == 0, "R1", rd_ptr, 0);
    rst_n = 1'b1;
    step();

    // sweep every start position, runs of 1..6, some crossing 31->0
    for (int s = 0; s < N_ENT; s++) begin
      run_seq(s, 1 + (s % 6), (s * 5) & 6'h3F, 1'b0);
    end
    run_seq(29, 5, 6'b000101, 1'b0);

    // R10: start and control writes during a run
    run_seq(10, 3, 0, 1'b1);
    chk(rd_ptr == 5'd12, "R10", rd_ptr, 12);

    // R7: delayed entry with count 5
    tick_en = 1'b1;
    prog(3, 1'b1, 1'b0, 1'b1, 8'hA5);
    setctl(3, 5, 1'b0);
    pulse_start();
    tick_cnt = 0;
    recv(8'hA5, "R7", 0);
    chk(tick_cnt >= 5 && tick_cnt <= 6, "R7", tick_cnt, 5);
    step();

    // R7: delay flag set but count 0, then flag clear with count 7
    for (int m = 0; m < 2; m++) begin
      int t0;
      prog(4, m == 0, 1'b0, 1'b1, 8'h3C + m);
      setctl(4, (m == 0) ? 0 : 7, 1'b0);
      pulse_start();
      t0 = cyc_n;
      recv(8'h3C + m, "R7", 0);
      chk(cyc_n - t0 <= 3, "R7", cyc_n - t0, 2);
      step();
    end
    tick_en = 1'b0;

    // R8: freq_chg with coupling clear, then set
    prog(6, 1'b0, 1'b0, 1'b1, 8'h66);
    setctl(6, 0, 1'b0);
    freq_chg = 1'b1; step(); freq_chg = 1'b0;
    for (int w = 0; w < 4; w++) step();
    chk(busy == 1'b0 && byte_valid == 1'b0, "R8", busy, 0);
    setctl(6, 0, 1'b1);
    freq_chg = 1'b1; step(); freq_chg = 1'b0;
    recv(8'h66, "R8", 0);
    chk(done == 1'b1, "R8", done, 1);
    step();

    // R11: field positions, burst flag at bit 9 lets entry 8 follow without ack
    prog(7, 1'b0, 1'b1, 1'b0, 8'h71);
    bank_wr = 1'b1; bank_addr = 5'd8; bank_wdata = 11'h1_82; step(); bank_wr = 1'b0;
    setctl(7, 0, 1'b0);
    pulse_start();
    recv(8'h71, "R11", 0);
    recv(8'h82, "R11", 0);
    chk(done == 1'b1 && rd_ptr == 5'd8, "R11", rd_ptr, 8);
    step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc_n, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule